// File: doc/BRIEF.md
# Ternary Class Code Matcher

This block scores a binary classifier on a test set. Each test sample arrives as a small vector of characteristic function bits, together with the sample's true class. The block fetches the stored reference code for that class and compares the two. Each position of a reference code is 0, 1 or don't-care, and a don't-care position matches either input value. Each class has its own comparator and two saturating counters. One counter holds the samples seen for that class and the other holds the samples that matched. The success ratio can then be formed outside the block.

The reference codes sit in a code table. A separate association table names the row of the code table that each class uses, so the rows may appear in any order. Both tables are elaboration-time parameters. Two push buttons step a selector forward and back through the classes. The display outputs show the selected class index and its two counts. A clear input zeroes every counter before a new test run starts.

Top module: `tern_code_matcher`

## Requirements
- R1: Position j of a code is stored as bit j of a care word and bit j of a value word. The position matches when its care bit is 0, or when the input bit equals the value bit. A sample matches only when all positions match.
- R2: The code for class c is row ROW_MAP[c*ID_W +: ID_W] of the code table. Row r occupies bits [r*CODE_W +: CODE_W] of CARE_TABLE and of VALUE_TABLE.
- R3: A valid sample of class c increments that class's sample counter by one, at the clock edge that accepts it. No other class's counters change.
- R4: A valid sample increments its class's hit counter only when it matches. The hit count never exceeds the sample count.
- R5: Both counters saturate at 2^CNT_W-1, which is 511 by default and so at least 300. They never wrap to a smaller value.
- R6: A sample whose class ID is NUM_CLASSES or larger changes no counter and produces no hit pulse.
- R7: While clear_i is high at an edge, every counter becomes 0. A sample presented in the same cycle is dropped. The selection is not affected.
- R8: A rising edge on btn_next_i advances the selection by one, and the last class wraps to class 0. A button held high moves the selection only once.
- R9: A rising edge on btn_prev_i moves the selection back by one, and class 0 wraps to NUM_CLASSES-1. When both buttons rise at the same edge, the selection does not move.
- R10: disp_class_o, disp_hits_o and disp_samples_o show the selected class and its counters. They reflect every update straight after the edge that makes it.
- R11: hit_o is high for the one cycle that follows an edge which accepted a matching sample, and is low at all other times.
- R12: After reset, all counters are 0, class 0 is selected and hit_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Zero all counters |
| sample_valid_i | input | 1 | A sample is presented this cycle |
| sample_class_i | input | ID_W | True class of the sample |
| sample_bits_i | input | CODE_W | Characteristic function bits of the sample |
| btn_next_i | input | 1 | Push button: next class |
| btn_prev_i | input | 1 | Push button: previous class |
| disp_class_o | output | ID_W | Selected class index |
| disp_hits_o | output | CNT_W | Matched-sample count of the selected class |
| disp_samples_o | output | CNT_W | Sample count of the selected class |
| hit_o | output | 1 | One-cycle pulse for a matched sample |

## Verification
Most internal faults in this block first appear on the display outputs. A wrong care or value bit, or a wrong row association, shows up as a hit count that drifts from the reference model. This happens at the first edge after a sample that exercises the bad position. A missing hit_o pulse shows up on the cycle right after that edge. A corrupt selector state or a lost button edge shows up at once on disp_class_o. A counter that wraps, or that ignores clear, shows up in the same cycle on the counts of the selected class. The bench therefore compares every output against a behavioural model at every clock and steps the selection through all classes.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_BACK = 2'd2
  } step_e;

  // Button edges -> selector move; simultaneous edges cancel.
  function automatic step_e decide_step(input logic fwd_edge, input logic back_edge);
    if (fwd_edge && !back_edge)      return STEP_FWD;
    else if (back_edge && !fwd_edge) return STEP_BACK;
    else                             return STEP_HOLD;
  endfunction

endpackage

// File: rtl/tcm_lane.sv
module tcm_lane #(
  parameter int CODE_W = 5,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              take_i,
  input  logic [CODE_W-1:0] bits_i,
  input  logic [CODE_W-1:0] care_i,
  input  logic [CODE_W-1:0] value_i,
  output logic              hit_o,
  output logic [CNT_W-1:0]  hits_q,
  output logic [CNT_W-1:0]  samples_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic code_match(input logic [CODE_W-1:0] b,
                                      input logic [CODE_W-1:0] c,
                                      input logic [CODE_W-1:0] v);
    return ((b ^ v) & c) == '0;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] x);
    return (x == CNT_MAX) ? x : x + 1'b1;
  endfunction

  assign hit_o = take_i && code_match(bits_i, care_i, value_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q    <= '0;
      samples_q <= '0;
    end else if (clear_i) begin
      hits_q    <= '0;
      samples_q <= '0;
    end else begin
      if (take_i) samples_q <= sat_inc(samples_q);
      if (hit_o)  hits_q    <= sat_inc(hits_q);
    end
  end

endmodule

// File: rtl/tcm_selector.sv
module tcm_selector #(
  parameter int NUM_CLASSES = 6,
  parameter int ID_W        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            btn_next_i,
  input  logic            btn_prev_i,
  output logic            step_fwd_o,
  output logic            step_back_o,
  output logic [ID_W-1:0] sel_q
);
  import tcm_pkg::*;

  localparam logic [ID_W-1:0] LAST = ID_W'(NUM_CLASSES - 1);

  logic  next_q, prev_q;
  step_e step;

  assign step        = decide_step(btn_next_i && !next_q, btn_prev_i && !prev_q);
  assign step_fwd_o  = (step == STEP_FWD);
  assign step_back_o = (step == STEP_BACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= 1'b0;
      prev_q <= 1'b0;
      sel_q  <= '0;
    end else begin
      next_q <= btn_next_i;
      prev_q <= btn_prev_i;
      unique case (step)
        STEP_FWD:  sel_q <= (sel_q == LAST) ? '0 : sel_q + 1'b1;
        STEP_BACK: sel_q <= (sel_q == '0) ? LAST : sel_q - 1'b1;
        default:   sel_q <= sel_q;
      endcase
    end
  end

endmodule

// File: rtl/tern_code_matcher.sv
module tern_code_matcher #(
  parameter int NUM_CLASSES = 6,
  parameter int CODE_W      = NUM_CLASSES - 1,
  parameter int CNT_W       = 9,
  parameter int ID_W        = $clog2(NUM_CLASSES),
  parameter logic [NUM_CLASSES*CODE_W-1:0] CARE_TABLE =
    {5'b11111, 5'b11111, 5'b01111, 5'b00111, 5'b00011, 5'b00001},
  parameter logic [NUM_CLASSES*CODE_W-1:0] VALUE_TABLE =
    {5'b11111, 5'b01111, 5'b00111, 5'b00011, 5'b00001, 5'b00000},
  parameter logic [NUM_CLASSES*ID_W-1:0] ROW_MAP =
    {3'd2, 3'd1, 3'd4, 3'd0, 3'd5, 3'd3}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sample_valid_i,
  input  logic [ID_W-1:0]   sample_class_i,
  input  logic [CODE_W-1:0] sample_bits_i,
  input  logic              btn_next_i,
  input  logic              btn_prev_i,
  output logic [ID_W-1:0]   disp_class_o,
  output logic [CNT_W-1:0]  disp_hits_o,
  output logic [CNT_W-1:0]  disp_samples_o,
  output logic              hit_o
);

  // Named internal events for the checker
  logic [NUM_CLASSES-1:0] lane_take;
  logic [NUM_CLASSES-1:0] lane_hit;
  logic                   step_fwd, step_back;

  logic [CNT_W-1:0] hits_arr    [NUM_CLASSES];
  logic [CNT_W-1:0] samples_arr [NUM_CLASSES];
  logic [ID_W-1:0]  sel_q;
  logic             hit_q;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_lane
    localparam int ROW = int'(ROW_MAP[c*ID_W +: ID_W]);
    localparam logic [CODE_W-1:0] CARE  = CARE_TABLE[ROW*CODE_W +: CODE_W];
    localparam logic [CODE_W-1:0] VALUE = VALUE_TABLE[ROW*CODE_W +: CODE_W];

    assign lane_take[c] = sample_valid_i && !clear_i && (sample_class_i == ID_W'(c));

    tcm_lane #(.CODE_W(CODE_W), .CNT_W(CNT_W)) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (clear_i),
      .take_i    (lane_take[c]),
      .bits_i    (sample_bits_i),
      .care_i    (CARE),
      .value_i   (VALUE),
      .hit_o     (lane_hit[c]),
      .hits_q    (hits_arr[c]),
      .samples_q (samples_arr[c])
    );
  end

  tcm_selector #(.NUM_CLASSES(NUM_CLASSES), .ID_W(ID_W)) sel_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .btn_next_i  (btn_next_i),
    .btn_prev_i  (btn_prev_i),
    .step_fwd_o  (step_fwd),
    .step_back_o (step_back),
    .sel_q       (sel_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= |lane_hit;
  end

  always_comb begin
    disp_hits_o    = '0;
    disp_samples_o = '0;
    for (int c = 0; c < NUM_CLASSES; c++) begin
      if (sel_q == ID_W'(c)) begin
        disp_hits_o    = hits_arr[c];
        disp_samples_o = samples_arr[c];
      end
    end
  end

  assign disp_class_o = sel_q;
  assign hit_o        = hit_q;

endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
  parameter int NUM_CLASSES = 6,
  parameter int ID_W        = 3,
  parameter int CNT_W       = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   clear_i,
  input logic                   btn_next_i,
  input logic                   btn_prev_i,
  input logic [ID_W-1:0]        disp_class_o,
  input logic [CNT_W-1:0]       disp_hits_o,
  input logic [CNT_W-1:0]       disp_samples_o,
  input logic                   hit_o,
  input logic [NUM_CLASSES-1:0] lane_take,
  input logic [NUM_CLASSES-1:0] lane_hit,
  input logic                   step_fwd,
  input logic                   step_back
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_one_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_take) && $onehot0(lane_hit));

  assert_hit_needs_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_hit & ~lane_take) == '0);

  assert_hit_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(lane_hit != '0));

  assert_hits_le_samples_R4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_hits_o <= disp_samples_o);

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear_i) |-> (disp_hits_o == '0 && disp_samples_o == '0 && !hit_o));

  assert_sel_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    disp_class_o < ID_W'(NUM_CLASSES));

  assert_sel_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!step_fwd && !step_back) |-> $stable(disp_class_o));

  assert_no_step_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!btn_next_i && !btn_prev_i) |-> (!step_fwd && !step_back));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(disp_samples_o) == CNT_MAX && $stable(disp_class_o) && !$past(clear_i))
      |-> disp_samples_o == CNT_MAX);

endmodule

bind tern_code_matcher tcm_checker #(
  .NUM_CLASSES(NUM_CLASSES), .ID_W(ID_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i),
  .btn_next_i(btn_next_i), .btn_prev_i(btn_prev_i),
  .disp_class_o(disp_class_o), .disp_hits_o(disp_hits_o),
  .disp_samples_o(disp_samples_o), .hit_o(hit_o),
  .lane_take(lane_take), .lane_hit(lane_hit),
  .step_fwd(step_fwd), .step_back(step_back)
);

// File: tb/tern_code_matcher_tb.sv
module tern_code_matcher_tb_top;

  localparam int NC   = 6;
  localparam int CW   = 5;
  localparam int CNTW = 9;
  localparam int IDW  = 3;
  localparam int MAXC = 511;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 1'b0, sample_valid_i = 1'b0, btn_next_i = 1'b0, btn_prev_i = 1'b0;
  logic [IDW-1:0]  sample_class_i = '0;
  logic [CW-1:0]   sample_bits_i = '0;
  logic [IDW-1:0]  disp_class_o;
  logic [CNTW-1:0] disp_hits_o, disp_samples_o;
  logic            hit_o;

  always #2 clk = ~clk;

  tern_code_matcher #(
    .NUM_CLASSES(NC), .CODE_W(CW), .CNT_W(CNTW), .ID_W(IDW),
    .CARE_TABLE ({5'b11111, 5'b11111, 5'b01111, 5'b00111, 5'b00011, 5'b00001}),
    .VALUE_TABLE({5'b11111, 5'b01111, 5'b00111, 5'b00011, 5'b00001, 5'b00000}),
    .ROW_MAP    ({3'd2, 3'd1, 3'd4, 3'd0, 3'd5, 3'd3})
  ) dut_i (.*);

  // Model: code per class as a string over positions 4..0, '-' = don't care.
  string code_of [NC] = '{"-0111", "11111", "----0", "01111", "---01", "--011"};
  int hits [NC];
  int samps[NC];
  int sel, m_hit, m_nq, m_pq;
  int checks = 0, failures = 0;

  function automatic int model_match(int cls, logic [CW-1:0] b);
    for (int j = 0; j < CW; j++) begin
      byte ch = code_of[cls][CW-1-j];
      if (ch == "1" && b[j] !== 1'b1) return 0;
      if (ch == "0" && b[j] !== 1'b0) return 0;
    end
    return 1;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "disp_class", int'(disp_class_o), sel);
    chk(tag, "disp_hits", int'(disp_hits_o), hits[sel]);
    chk(tag, "disp_samples", int'(disp_samples_o), samps[sel]);
    chk(tag, "hit_o", int'(hit_o), m_hit);
  endtask

  // One clock: drive at negedge, model the edge, compare after it.
  task automatic step(string tag, bit v, int cls, logic [CW-1:0] b,
                      bit clr = 0, bit nx = 0, bit pv = 0);
    int rn, rp;
    @(negedge clk);
    sample_valid_i = v; sample_class_i = IDW'(cls); sample_bits_i = b;
    clear_i = clr; btn_next_i = nx; btn_prev_i = pv;
    @(posedge clk);
    m_hit = 0;
    if (clr) begin
      for (int c = 0; c < NC; c++) begin hits[c] = 0; samps[c] = 0; end
    end else if (v && cls < NC) begin
      if (samps[cls] < MAXC) samps[cls]++;
      if (model_match(cls, b)) begin
        m_hit = 1;
        if (hits[cls] < MAXC) hits[cls]++;
      end
    end
    rn = nx && !m_nq; rp = pv && !m_pq;
    if (rn && !rp) sel = (sel + 1) % NC;
    else if (rp && !rn) sel = (sel + NC - 1) % NC;
    m_nq = nx; m_pq = pv;
    #1 compare(tag);
  endtask

  task automatic press_next(string tag);
    step(tag, 0, 0, '0, 0, 1, 0);
    step(tag, 0, 0, '0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) begin hits[c] = 0; samps[c] = 0; end
    sel = 0; m_hit = 0; m_nq = 0; m_pq = 0;
    repeat (3) @(posedge clk);
    #1 compare("R12");
    @(negedge clk) rst_n = 1'b1;
    step("R12", 0, 0, '0);

    // R1 R2: per-class matches and misses, incl. don't-care positions
    step("R1", 1, 0, 5'b00111);  // class0 match
    step("R1", 1, 0, 5'b10111);  // class0 match via don't care at pos4
    step("R1", 1, 0, 5'b00110);  // class0 miss
    step("R2", 1, 1, 5'b11111);  // class1 match
    step("R2", 1, 1, 5'b11110);  // class1 miss
    step("R2", 1, 2, 5'b11110);  // class2 match (pos0=0)
    step("R2", 1, 2, 5'b00001);  // class2 miss
    step("R2", 1, 3, 5'b01111);
    step("R2", 1, 4, 5'b10101);  // class4 match
    step("R2", 1, 4, 5'b00011);  // class4 miss
    step("R2", 1, 5, 5'b01011);  // class5 match
    step("R3", 1, 5, 5'b00111);  // class5 miss
    // R6: out-of-range IDs
    step("R6", 1, 6, 5'b11111);
    step("R6", 1, 7, 5'b00000);
    // R10: walk the display across all classes, R8 wrap at the end
    for (int k = 0; k < NC; k++) press_next("R10");
    // R8: held button moves once
    step("R8", 0, 0, '0, 0, 1, 0);
    step("R8", 0, 0, '0, 0, 1, 0);
    step("R8", 0, 0, '0, 0, 1, 0);
    step("R8", 0, 0, '0);
    // R9: back twice, wrap from 0 to last, both buttons cancel
    step("R9", 0, 0, '0, 0, 0, 1);
    step("R9", 0, 0, '0);
    step("R9", 0, 0, '0, 0, 0, 1);
    step("R9", 0, 0, '0);
    step("R9", 0, 0, '0, 0, 1, 1);
    step("R9", 0, 0, '0);
    // R11: hit pulse shape on back-to-back samples
    step("R11", 1, 5, 5'b11011);
    step("R11", 1, 5, 5'b11011);
    step("R11", 0, 5, 5'b11011);
    // R7: clear with a concurrent matching sample, selection kept
    step("R7", 1, 5, 5'b00011, 1);
    step("R7", 0, 0, '0);
    // R5: saturate class 0 (selection back to 0 first)
    press_next("R5");
    for (int k = 0; k < MAXC + 9; k++) step("R5", 1, 0, 5'b00111);
    step("R4", 1, 0, 5'b00000);
    step("R5", 0, 0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule